// File: doc/BRIEF.md
# Rotate Mask Generator

This unit rotates a 32-bit source word left by a 5-bit amount and builds a 32-bit selection mask from a begin index and an end index. It returns both the mask and the rotated word filtered by that mask. Bit positions are counted from the most significant end, so position 0 is the MSB and position 31 is the LSB. When the end index is at or after the begin index, the mask covers that single run of positions. When the end index comes before the begin index, the mask wraps around, covering the tail from the begin index and the head up to the end index.

A second mode, insert, keeps the bits of a destination word wherever the mask is clear and takes the rotated source wherever it is set. The three 5-bit controls arrive packed in one 16-bit control word, in the layout an instruction decoder already extracts. The lowest bit of that word is a flag that belongs to the decoder, and this unit ignores it.

The datapath is combinational. A single register stage on the output gives a fixed latency of one cycle and a valid strobe that travels with each result.

Top module: `rmg_rotmask_unit`

## Requirements
- R1: The control word carries the rotate amount in bits 15:11, the begin index in bits 10:6 and the end index in bits 5:1. Bit 0 has no effect on any output.
- R2: When the end index is greater than or equal to the begin index, the mask has exactly the positions from begin to end set, inclusive, where position 0 is mask bit 31.
- R3: When the begin and end indices are equal, exactly one mask bit is set.
- R4: A begin index of 0 with an end index of 31 gives a mask of all ones.
- R5: When the end index is below the begin index, the mask has positions begin..31 and 0..end set. This equals the bitwise inverse of the run from end+1 to begin-1.
- R6: The source is rotated left by the rotate amount. An amount of 0 passes the source unchanged.
- R7: With insert_en low, the result is the rotated source AND the mask.
- R8: With insert_en high, the result is (rotated source AND mask) OR (dst_data AND NOT mask).
- R9: A request accepted with in_valid high in one cycle appears on mask_out and result_out, with out_valid high, one cycle later. A synchronous reset clears out_valid, mask_out and result_out to 0.
- R10: In a cycle where in_valid is low, out_valid is low one cycle later, and mask_out and result_out keep their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| insert_en | input | 1 | 1 selects insert mode, 0 selects the masked rotate |
| ctrl_word | input | 16 | Packed rotate amount, begin index, end index and ignored flag |
| src_data | input | 32 | Word to rotate |
| dst_data | input | 32 | Word whose bits survive outside the mask in insert mode |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| mask_out | output | 32 | Generated mask |
| result_out | output | 32 | Masked or merged rotate result |

## Verification
Directed cases cover several index pairs. Equal begin and end indices separate single-bit masks from off-by-one run edges. The full-width pair and the wrap pairs, including end directly below begin, distinguish the inverted form from a plain run and show whether the comparison is strict. A zero rotate amount and a one-position rotate expose a reversed direction or a missing stage. Insert requests with a destination that differs from the source show whether the merge takes each bit from the correct side. Random requests arrive both back to back and with gaps, with the ignored flag toggled. Stretches with the strobe low, while the other inputs change, check that the outputs hold.

// File: rtl/rmg_pkg.sv
package rmg_pkg;

    // Datapath geometry
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = $clog2(DATA_W);
    localparam int unsigned CTRL_W = 3 * IDX_W + 1;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;

    // Control word layout, MSB first: amount, begin, end, decoder flag
    typedef struct packed {
        idx_t amount;
        idx_t first;
        idx_t last;
        logic flag;
    } ctrl_t;

    // Registered output bundle
    typedef struct packed {
        logic  valid;
        word_t mask;
        word_t result;
    } out_t;

    // True when big-endian position pos lies inside the mask selected by first/last
    function automatic logic pos_selected(idx_t pos, idx_t first, idx_t last);
        logic after_first;
        logic before_last;
        after_first = (pos >= first);
        before_last = (pos <= last);
        if (last < first)
            return after_first | before_last;
        return after_first & before_last;
    endfunction

endpackage

// File: rtl/rmg_mask_gen.sv
module rmg_mask_gen
    import rmg_pkg::*;
(
    input  idx_t  first,
    input  idx_t  last,
    output word_t mask
);

    // Little-endian bit i holds big-endian position DATA_W-1-i
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam idx_t POS = idx_t'(DATA_W - 1 - i);
        assign mask[i] = pos_selected(POS, first, last);
    end

endmodule

// File: rtl/rmg_rotator.sv
module rmg_rotator
    import rmg_pkg::*;
(
    input  word_t src,
    input  idx_t  amount,
    output word_t rotated
);

    // Logarithmic rotate: stage k rotates left by 2**k when amount[k] is set
    word_t stage [IDX_W+1];

    assign stage[0] = src;

    for (genvar k = 0; k < IDX_W; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        assign stage[k+1] = amount[k]
            ? {stage[k][DATA_W-1-STEP:0], stage[k][DATA_W-1 -: STEP]}
            : stage[k];
    end

    assign rotated = stage[IDX_W];

endmodule

// File: rtl/rmg_merge.sv
module rmg_merge
    import rmg_pkg::*;
(
    input  logic  insert,
    input  word_t rotated,
    input  word_t dst,
    input  word_t mask,
    output word_t result
);

    word_t kept;

    // Bits outside the mask come from dst in insert mode, else they are zero
    assign kept   = insert ? (dst & ~mask) : '0;
    assign result = (rotated & mask) | kept;

endmodule

// File: rtl/rmg_rotmask_unit.sv
module rmg_rotmask_unit
    import rmg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 insert_en,
    input  logic [CTRL_W-1:0]    ctrl_word,
    input  logic [DATA_W-1:0]    src_data,
    input  logic [DATA_W-1:0]    dst_data,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    mask_out,
    output logic [DATA_W-1:0]    result_out
);

    ctrl_t ctrl;
    word_t mask_c;
    word_t rot_c;
    word_t res_c;
    out_t  out_q;
    logic  unused_flag;

    assign ctrl        = ctrl_t'(ctrl_word);
    assign unused_flag = ctrl.flag;   // decoder flag, ignored here

    rmg_mask_gen u_mask (
        .first (ctrl.first),
        .last  (ctrl.last),
        .mask  (mask_c)
    );

    rmg_rotator u_rot (
        .src     (src_data),
        .amount  (ctrl.amount),
        .rotated (rot_c)
    );

    rmg_merge u_merge (
        .insert  (insert_en),
        .rotated (rot_c),
        .dst     (dst_data),
        .mask    (mask_c),
        .result  (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_valid;
            if (in_valid) begin
                out_q.mask   <= mask_c;
                out_q.result <= res_c;
            end
        end
    end

    assign out_valid  = out_q.valid;
    assign mask_out   = out_q.mask;
    assign result_out = out_q.result;

    // Requirement checks on the registered outputs

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(mask_out) && $stable(result_out)));

    assert_single_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl.first == ctrl.last) |=> ($countones(mask_out) == 1));

    assert_full_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl.first == '0 && ctrl.last == idx_t'(DATA_W - 1)) |=> (&mask_out));

    assert_wrap_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl.last < ctrl.first) |=> (mask_out[DATA_W-1] && mask_out[0]));

    assert_outside_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !insert_en) |=> ((result_out & ~mask_out) == '0));

    assert_outside_dst_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && insert_en) |=> (((result_out ^ $past(dst_data)) & ~mask_out) == '0));

    assert_pass_through_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !insert_en && ctrl.amount == '0 && ctrl.first == '0
         && ctrl.last == idx_t'(DATA_W - 1)) |=> (result_out == $past(src_data)));

endmodule

// File: tb/tb_rmg_rotmask_unit.sv
module tb_rmg_rotmask_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        insert_en;
    logic [15:0] ctrl_word;
    logic [31:0] src_data;
    logic [31:0] dst_data;
    logic        out_valid;
    logic [31:0] mask_out;
    logic [31:0] result_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] exp_mask_q[$];
    logic [31:0] exp_res_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    rmg_rotmask_unit dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .insert_en  (insert_en),
        .ctrl_word  (ctrl_word),
        .src_data   (src_data),
        .dst_data   (dst_data),
        .out_valid  (out_valid),
        .mask_out   (mask_out),
        .result_out (result_out)
    );

    function automatic logic [31:0] ref_mask(int b, int e);
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] x;
        hi = 32'hFFFF_FFFF >> b;
        lo = 32'h7FFF_FFFF >> e;
        x  = hi ^ lo;
        return (e < b) ? ~x : x;
    endfunction

    function automatic logic [31:0] ref_rot(logic [31:0] s, int n);
        logic [63:0] d;
        d = {s, s} << n;
        return d[63:32];
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: applies one request and queues its expected outcome
    task automatic send(bit ins, int sh, int b, int e, bit flag,
                        logic [31:0] s, logic [31:0] d, string tag);
        logic [31:0] m;
        logic [31:0] r;
        @(negedge clk);
        in_valid  = 1'b1;
        insert_en = ins;
        ctrl_word = {sh[4:0], b[4:0], e[4:0], flag};
        src_data  = s;
        dst_data  = d;
        m = ref_mask(b, e);
        r = (ref_rot(s, sh) & m) | (ins ? (d & ~m) : 32'h0);
        exp_mask_q.push_back(m);
        exp_res_q.push_back(r);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compares each result against the oldest queued expectation
    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            if (exp_mask_q.size() == 0) begin
                check(1'b0, "R9 unexpected out_valid", {31'h0, out_valid}, 32'h0);
            end else begin
                logic [31:0] em;
                logic [31:0] er;
                string       t;
                em = exp_mask_q.pop_front();
                er = exp_res_q.pop_front();
                t  = tag_q.pop_front();
                check(mask_out == em, {t, " mask"}, mask_out, em);
                check(result_out == er, {t, " result"}, result_out, er);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_m;
        logic [31:0] held_r;
        rst       = 1'b1;
        in_valid  = 1'b0;
        insert_en = 1'b0;
        ctrl_word = 16'hFFFF;
        src_data  = 32'hDEAD_BEEF;
        dst_data  = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9 reset out_valid", {31'h0, out_valid}, 32'h0);
        check(mask_out == 32'h0, "R9 reset mask", mask_out, 32'h0);
        check(result_out == 32'h0, "R9 reset result", result_out, 32'h0);
        rst = 1'b0;

        // R2 contiguous runs
        send(0, 0, 4, 11, 0, 32'hFFFF_FFFF, 32'h0, "R2 run 4..11");
        send(0, 8, 16, 31, 0, 32'h0000_00AB, 32'h0, "R2 low half");
        // R3 single bit
        send(0, 0, 5, 5, 0, 32'hFFFF_FFFF, 32'h0, "R3 single bit 5");
        send(0, 3, 0, 0, 0, 32'hF000_0001, 32'h0, "R3 single bit 0");
        send(0, 0, 31, 31, 0, 32'hFFFF_FFFF, 32'h0, "R3 single bit 31");
        // R4 full mask
        send(0, 13, 0, 31, 0, 32'h8000_0001, 32'h0, "R4 full mask");
        // R5 wrap
        send(0, 0, 30, 1, 0, 32'hFFFF_FFFF, 32'h0, "R5 wrap 30/1");
        send(0, 0, 16, 15, 0, 32'hFFFF_FFFF, 32'h0, "R5 wrap adjacent");
        send(0, 2, 31, 0, 0, 32'h1234_5678, 32'h0, "R5 wrap ends");
        // R6 rotate
        send(0, 0, 0, 31, 0, 32'hCAFE_F00D, 32'h0, "R6 amount zero");
        send(0, 1, 0, 31, 0, 32'h8000_0001, 32'h0, "R6 amount one");
        send(0, 31, 0, 31, 0, 32'h0000_0003, 32'h0, "R6 amount 31");
        // R7 / R8
        send(0, 4, 8, 23, 0, 32'h0F0F_0F0F, 32'hFFFF_FFFF, "R7 masked rotate ignores dst");
        send(1, 4, 8, 23, 0, 32'h0F0F_0F0F, 32'hA5A5_A5A5, "R8 insert run");
        send(1, 20, 28, 3, 0, 32'h1357_9BDF, 32'h0000_0000, "R8 insert wrap");
        send(1, 0, 10, 10, 0, 32'h0000_0000, 32'hFFFF_FFFF, "R8 insert single");
        // R1 flag bit ignored
        send(0, 7, 3, 20, 1, 32'h89AB_CDEF, 32'h0, "R1 flag set");
        send(1, 7, 3, 20, 1, 32'h89AB_CDEF, 32'h5555_AAAA, "R1 flag set insert");
        idle();
        idle();

        // R10: outputs hold while in_valid low and other inputs change
        @(negedge clk);
        held_m = mask_out;
        held_r = result_out;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ctrl_word = 16'($urandom);
            src_data  = $urandom;
            dst_data  = $urandom;
            insert_en = ~insert_en;
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R10 idle out_valid", {31'h0, out_valid}, 32'h0);
        check(mask_out == held_m, "R10 mask held", mask_out, held_m);
        check(result_out == held_r, "R10 result held", result_out, held_r);

        // Random mix, back to back and with gaps
        for (int n = 0; n < 400; n++) begin
            bit ins;
            ins = 1'($urandom);
            send(ins, int'($urandom % 32), int'($urandom % 32), int'($urandom % 32),
                 1'($urandom), $urandom, $urandom,
                 ins ? "R8 random insert" : "R7 random rotate");
            if (($urandom % 4) == 0) idle();
        end
        idle();
        repeat (3) @(negedge clk);
        check(exp_mask_q.size() == 0, "R9 all results delivered",
              32'(exp_mask_q.size()), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule